// File: doc/BRIEF.md
# Triple-Pass Feistel Block Sequencer (EDE, 32-bit Bus)

This block controls a triple-pass block cipher engine that talks to its host over one 32-bit input port and one 32-bit output port. A 64-bit text block and three 64-bit keys arrive as word pairs on the shared input. The block then makes three passes over the text: forward with the first key, inverse with the second, and forward with the third. It uses a single iterative round datapath that retires one round per clock, and the subkeys are derived from the round index. The result leaves as two 32-bit words marked by a valid strobe. A one-cycle request strobe tells the host to present the next key.

The block runs on a fixed frame of 4 + 3*ROUNDS + 2 clocks, which is 54 with the default 16 rounds. The frame starts on the first clock after reset is released, and frames follow one another with no gap. The key for a later pass is taken during the last two rounds of the pass before it, so key loading never stalls the rounds. The round function is a stand-in Feistel round defined below; a production round function would replace it without changing the sequencing.

Top module: `tdes_seq`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high, and on the first clock after it falls, `dout_vld` and `key_req` are low. The frame restarts at offset 0 on the first clock after `rst` falls, even if reset was applied partway through a frame.
- R2: Every 64-bit quantity arrives as two words, upper word first. The text is sampled at frame offsets 0 and 1, key A at offsets 2 and 3, key B at offsets ROUNDS+2 and ROUNDS+3 (18 and 19), and key C at offsets 2*ROUNDS+2 and 2*ROUNDS+3 (34 and 35).
- R3: `key_req` is high for exactly one clock, at offsets 1, ROUNDS+1 and 2*ROUNDS+1 (1, 17, 33). Each of these is one clock before the upper word of a key is sampled. At all other offsets it is low.
- R4: `dout_vld` is high exactly at offsets 3*ROUNDS+4 and 3*ROUNDS+5 (52, 53). On those clocks `dout` carries the upper and then the lower result word. While `dout_vld` is low, `dout` is zero.
- R5: The result is F_C(I_B(F_A(P))). F is a forward pass, I is an inverse pass, and the text register carries each pass's output into the next pass.
- R6: A pass splits the block into L (bits 63:32) and R (bits 31:0) and runs ROUNDS rounds i = 0..ROUNDS-1. The key index is j = i for a forward pass and j = ROUNDS-1-i for an inverse pass. The subkey is bits 63:32 of the key rotated left by (3*(j+1)) mod 64. Let t = R xor subkey and u = (t + 0x9E3779B9) mod 2^32. Then f = rotl32(u, 7) xor t. Each round except the last sets (L,R) to (R, L xor f); the last round sets L to L xor f and keeps R.
- R7: When key A equals key B, the result equals a single forward pass of P with key C.
- R8: Values on `din` at offsets other than those in R2 have no effect on the result.
- R9: Frames repeat back to back with a period of 4 + 3*ROUNDS + 2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 32 | Shared text and key word input |
| dout | output | 32 | Result word output, zero when not valid |
| dout_vld | output | 1 | High on the two result clocks |
| key_req | output | 1 | One-clock request for the next key |

## Verification
The hardest cases to reach from the ports are a reset that lands in the middle of a pass and a key that arrives while the previous pass is still running. The bench forces the first by raising `rst` at offset 30, after key B has been taken and before key C. It then checks that the next full frame starts cleanly. The second case is exercised in every frame, because frames run back to back and non-load offsets carry changing junk words. A wrong sampling offset or a key update that races the last round would therefore corrupt the result.

// File: rtl/tdes_seq.sv
module tdes_seq #(
  parameter int ROUNDS = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] din,
  output logic [31:0] dout,
  output logic        dout_vld,
  output logic        key_req
);
  localparam int TOTAL = 4 + 3 * ROUNDS + 2;
  localparam int CW = $clog2(TOTAL);
  localparam int RW = $clog2(ROUNDS);

  localparam logic [CW-1:0] O_TXT_HI = CW'(0);
  localparam logic [CW-1:0] O_TXT_LO = CW'(1);
  localparam logic [CW-1:0] O_KA_HI  = CW'(2);
  localparam logic [CW-1:0] O_KA_LO  = CW'(3);
  localparam logic [CW-1:0] O_P0     = CW'(4);
  localparam logic [CW-1:0] O_P1     = CW'(4 + ROUNDS);
  localparam logic [CW-1:0] O_P2     = CW'(4 + 2 * ROUNDS);
  localparam logic [CW-1:0] O_OUT    = CW'(4 + 3 * ROUNDS);
  localparam logic [CW-1:0] O_LAST   = CW'(TOTAL - 1);
  localparam logic [CW-1:0] O_KB_HI  = CW'(2 + ROUNDS);
  localparam logic [CW-1:0] O_KB_LO  = CW'(3 + ROUNDS);
  localparam logic [CW-1:0] O_KC_HI  = CW'(2 + 2 * ROUNDS);
  localparam logic [CW-1:0] O_KC_LO  = CW'(3 + 2 * ROUNDS);
  localparam logic [CW-1:0] O_RQ_A   = CW'(1);
  localparam logic [CW-1:0] O_RQ_B   = CW'(1 + ROUNDS);
  localparam logic [CW-1:0] O_RQ_C   = CW'(1 + 2 * ROUNDS);
  localparam logic [RW-1:0] R_LAST   = RW'(ROUNDS - 1);

  logic [CW-1:0]  cyc;
  logic [31:0]    hold;
  logic [63:0]    blk;
  logic [63:0]    key;

  logic           in_pass, inv;
  logic [CW-1:0]  base, off;
  logic [RW-1:0]  rnd, kidx;
  logic [5:0]     rot;
  logic [127:0]   dbl;
  logic [31:0]    sk, t, u, f, lh, rh;
  logic [63:0]    nxt;

  assign in_pass = (cyc >= O_P0) && (cyc < O_OUT);
  assign inv     = (cyc >= O_P1) && (cyc < O_P2);
  assign base    = (cyc >= O_P2) ? O_P2 : (cyc >= O_P1) ? O_P1 : O_P0;
  assign off     = cyc - base;
  assign rnd     = off[RW-1:0];
  assign kidx    = inv ? (R_LAST - rnd) : rnd;
  assign rot     = 6'((32'(kidx) + 32'd1) * 32'd3);
  assign dbl     = {key, key} << rot;
  assign sk      = dbl[127:96];
  assign lh      = blk[63:32];
  assign rh      = blk[31:0];
  assign t       = rh ^ sk;
  assign u       = t + 32'h9E37_79B9;
  assign f       = {u[24:0], u[31:25]} ^ t;
  assign nxt     = (rnd == R_LAST) ? {lh ^ f, rh} : {rh, lh ^ f};

  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc == O_LAST) cyc <= '0;
    else cyc <= cyc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) hold <= '0;
    else if (cyc == O_TXT_HI || cyc == O_KA_HI || cyc == O_KB_HI || cyc == O_KC_HI)
      hold <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) blk <= '0;
    else if (cyc == O_TXT_LO) blk <= {hold, din};
    else if (in_pass) blk <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) key <= '0;
    else if (cyc == O_KA_LO || cyc == O_KB_LO || cyc == O_KC_LO) key <= {hold, din};
  end

  assign dout_vld = (cyc >= O_OUT);
  assign dout     = !dout_vld ? 32'd0 : (cyc == O_OUT) ? blk[63:32] : blk[31:0];
  assign key_req  = (cyc == O_RQ_A) || (cyc == O_RQ_B) || (cyc == O_RQ_C);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dout_vld && !key_req));
  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    key_req |=> !key_req);
  assert_req_apart_R3: assert property (@(posedge clk) disable iff (rst)
    key_req |-> !dout_vld);
  assert_vld_pair_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_vld) |=> dout_vld);
  assert_vld_end_R4: assert property (@(posedge clk) disable iff (rst)
    (dout_vld && $past(dout_vld)) |=> !dout_vld);
  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !dout_vld |-> (dout == 32'd0));
  assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(dout_vld) |=> key_req);
endmodule

// File: tb/tdes_seq_tb.sv
`timescale 1ns/1ps
module tdes_seq_tb_top;
  localparam int ROUNDS = 16;
  localparam int TOTAL = 4 + 3 * ROUNDS + 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [31:0] din = '0;
  logic [31:0] dout;
  logic dout_vld, key_req;
  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [63:0] seed = 64'h1234_5678_9ABC_DEF0;

  always #2 clk = ~clk;

  tdes_seq #(.ROUNDS(ROUNDS)) dut_i (
    .clk(clk), .rst(rst), .din(din), .dout(dout), .dout_vld(dout_vld), .key_req(key_req));

  function automatic logic [63:0] nxt_rand(input logic [63:0] x);
    return x * 64'd6364136223846793005 + 64'd1442695040888963407;
  endfunction

  function automatic logic [31:0] rf(input logic [31:0] r, input logic [31:0] k);
    logic [31:0] t, u;
    t = r ^ k;
    u = t + 32'h9E37_79B9;
    return {u[24:0], u[31:25]} ^ t;
  endfunction

  function automatic logic [63:0] one_pass(input logic [63:0] b, input logic [63:0] k, input bit inv);
    logic [31:0] l, r, nf;
    logic [63:0] rk;
    int j, s;
    l = b[63:32]; r = b[31:0];
    for (int i = 0; i < ROUNDS; i++) begin
      j = inv ? ROUNDS - 1 - i : i;
      s = (3 * (j + 1)) % 64;
      rk = (s == 0) ? k : ((k << s) | (k >> (64 - s)));
      nf = l ^ rf(r, rk[63:32]);
      if (i == ROUNDS - 1) l = nf;
      else begin l = r; r = nf; end
    end
    return {l, r};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [63:0] p, input logic [63:0] ka, input logic [63:0] kb,
                           input logic [63:0] kc, input logic [63:0] expv, input string req,
                           input int abort_at);
    logic [31:0] hi;
    for (int o = 0; o < TOTAL; o++) begin
      bit rq_e, vl_e;
      rq_e = (o == 1) || (o == ROUNDS + 1) || (o == 2 * ROUNDS + 1);
      vl_e = (o >= 3 * ROUNDS + 4);
      if (o == abort_at) return;
      chk("R3 key_req", {63'd0, key_req}, {63'd0, rq_e});
      chk("R4 dout_vld", {63'd0, dout_vld}, {63'd0, vl_e});
      if (o == 3 * ROUNDS + 4) hi = dout;
      if (o == 3 * ROUNDS + 5) chk(req, {hi, dout}, expv);
      if (!vl_e) chk("R4 idle dout", {32'd0, dout}, 64'd0);
      seed = nxt_rand(seed);
      case (o)
        0: din = p[63:32];
        1: din = p[31:0];
        2: din = ka[63:32];
        3: din = ka[31:0];
        ROUNDS + 2: din = kb[63:32];
        ROUNDS + 3: din = kb[31:0];
        2 * ROUNDS + 2: din = kc[63:32];
        2 * ROUNDS + 3: din = kc[31:0];
        default: din = seed[47:16];
      endcase
      @(posedge clk); #1;
    end
  endtask

  function automatic logic [63:0] ede(input logic [63:0] p, input logic [63:0] ka,
                                      input logic [63:0] kb, input logic [63:0] kc);
    return one_pass(one_pass(one_pass(p, ka, 1'b0), kb, 1'b1), kc, 1'b0);
  endfunction

  initial begin
    logic [63:0] p, ka, kb, kc;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset vld", {63'd0, dout_vld}, 64'd0);
    chk("R1 reset req", {63'd0, key_req}, 64'd0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R5 zero keys", 64'd0, 64'd0);
    run_frame(64'h0123_4567_89AB_CDEF, 64'h0, 64'h0, 64'h0,
              ede(64'h0123_4567_89AB_CDEF, 64'h0, 64'h0, 64'h0), "R5 R6 zero keys", -1);
    run_frame(64'h0123_4567_89AB_CDEF, 64'h1334_5779_9BBC_DFF1, 64'hAABB_0918_2736_CCDD,
              64'h8899_AABB_CCDD_EEFF,
              ede(64'h0123_4567_89AB_CDEF, 64'h1334_5779_9BBC_DFF1, 64'hAABB_0918_2736_CCDD,
                  64'h8899_AABB_CCDD_EEFF), "R2 R5 fixed", -1);
    for (int n = 0; n < 20; n++) begin
      seed = nxt_rand(seed); p = seed;
      seed = nxt_rand(seed); ka = seed;
      seed = nxt_rand(seed); kb = seed;
      seed = nxt_rand(seed); kc = seed;
      run_frame(p, ka, kb, kc, ede(p, ka, kb, kc), "R5 R8 R9 sweep", -1);
    end
    for (int n = 0; n < 4; n++) begin
      seed = nxt_rand(seed); p = seed;
      seed = nxt_rand(seed); ka = seed;
      seed = nxt_rand(seed); kc = seed;
      run_frame(p, ka, ka, kc, one_pass(p, kc, 1'b0), "R7 A equals B", -1);
    end
    run_frame(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
              ede(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF),
              "R5 R6 all ones", 30);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 mid reset vld", {63'd0, dout_vld}, 64'd0);
    chk("R1 mid reset req", {63'd0, key_req}, 64'd0);
    @(posedge clk); #1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    run_frame(64'hDEAD_BEEF_0BAD_F00D, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888,
              64'h9999_AAAA_BBBB_CCCC,
              ede(64'hDEAD_BEEF_0BAD_F00D, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888,
                  64'h9999_AAAA_BBBB_CCCC), "R1 R5 after mid reset", -1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule